// File: doc/BRIEF.md
# Power Fault Supervisor and Start Sequencer

This block decides when the two PWM channels of an isolated converter controller may switch. It takes digital status flags as inputs: the controller supply, the reference, the input-voltage window, an enable pin whose active level is set by a second pin, two output-undervoltage flags and two flags that describe the bootstrap rail. From these it drives two run signals. The auxiliary channel is released first. The main channel is released only after the bootstrap rail has risen above the supply.

Faults come in two classes. A simple fault stops both channels at once: a bad reference, a lost supply, an input voltage outside its window, or the channel being disabled. Once the fault is gone and the bootstrap rail has collapsed, the block restarts by itself. An output-undervoltage condition that lasts a programmable number of clock cycles is handled differently. It latches the block off, and a deliberate restart action is needed to release it. A two-bit code records the cause of the most recent shutdown until the next restart.

Top module: `pwr_seq_supervisor`

## Requirements
- R1: The channel is enabled when `en_pin` XOR `prog_pin` is 1. With `prog_pin` high, a low enable pin allows switching. With `prog_pin` low, a high enable pin allows switching. If the channel is disabled while running, both run outputs fall on the next clock and the cause code becomes 2'b10.
- R2: If `ref_ok` is low, `supply_ok` is low, `vin_low` is high or `vin_high` is high at a clock edge, both run outputs are low after that edge. While running, such a fault records cause 2'b01.
- R3: After reset, all outputs are 0 and the cause is 2'b00. From this state, `run_aux` rises one clock after the supply, the reference, the input window and the enable are all good together.
- R4: `run_main` rises one clock after `boot_above` is sampled high while `run_aux` is high. `run_main` is never high while `run_aux` is low.
- R5: After a simple fault, the channels stay off until start conditions are good and `boot_low` is high in the same cycle. The restart then repeats the full order: auxiliary first, main on a later clock. Entering the auxiliary state clears the cause to 2'b00.
- R6: While running, if either undervoltage flag is high for max(`uv_limit`,1) consecutive clocks, the block enters the latched-off state. In that state `latched_off`=1, both run outputs are 0 and the cause is 2'b11. The timer does not run while the channels are off.
- R7: A single clock with both undervoltage flags low returns the timer to zero. Runs of undervoltage shorter than the limit, separated by such a clock, never latch.
- R8: The latched-off state is left only on a clock where all three of these hold: both undervoltage flags are low, `boot_low` is high, and `en_pin` or `vin_low` differs from its value on the previous clock. The block then waits off with cause 2'b11 retained, and restarts as in R5.
- R9: Cause codes are 2'b00 none, 2'b01 input/supply/reference fault, 2'b10 disabled, 2'b11 undervoltage timeout. When several apply on the same clock, timeout ranks above input fault, and input fault ranks above disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Controller supply above its start level |
| ref_ok | input | 1 | Internal reference in regulation |
| vin_low | input | 1 | Input voltage below its window |
| vin_high | input | 1 | Input voltage above its window |
| en_pin | input | 1 | Enable pin level |
| prog_pin | input | 1 | Selects the active level of the enable pin |
| uv_aux | input | 1 | Auxiliary output below regulation |
| uv_main | input | 1 | Main output below regulation |
| boot_low | input | 1 | Bootstrap rail has collapsed |
| boot_above | input | 1 | Bootstrap rail above the controller supply |
| uv_limit | input | CNT_W | Undervoltage timeout in clock cycles |
| run_aux | output | 1 | Auxiliary channel may switch |
| run_main | output | 1 | Main channel may switch |
| latched_off | output | 1 | Undervoltage timeout latch is set |
| fault_cause | output | 2 | Cause of the last shutdown |

## Verification
The assertions check the following relations on every cycle:
- An input fault is always followed by both channels being off.
- Every rise of either run output is justified by its start condition on the cycle before.
- A restart after a shutdown always saw `boot_low`.
- The latch only opens with both outputs recovered.
- The timer is zero after a clock with no undervoltage.

Only the bench scenarios can show the following:
- The exact count at which the timer trips, swept over several limits including zero.
- That non-consecutive undervoltage never trips.
- That the latch ignores toggles while an output is still low, or while the rail has not collapsed.
- The cause priorities when faults coincide.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_AUX   = 3'd1,
        ST_BOTH  = 3'd2,
        ST_HOLD  = 3'd3,
        ST_LATCH = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'b00,
        CAUSE_INPUT   = 2'b01,
        CAUSE_DISABLE = 2'b10,
        CAUSE_UVTIME  = 2'b11
    } cause_e;

    typedef struct packed {
        seq_state_e state;
        cause_e     cause;
        logic       en_prev;
        logic       vl_prev;
    } seq_regs_t;

endpackage

// File: rtl/pwr_cond_eval.sv
module pwr_cond_eval (
    input  logic supply_ok,
    input  logic ref_ok,
    input  logic vin_low,
    input  logic vin_high,
    input  logic en_pin,
    input  logic prog_pin,
    input  logic uv_aux,
    input  logic uv_main,
    output logic enabled,
    output logic input_bad,
    output logic start_ok,
    output logic uv_any,
    output logic uv_clear
);
    always_comb begin
        // prog high: active-low enable; prog low: active-high enable
        enabled   = en_pin ^ prog_pin;
        input_bad = !supply_ok || !ref_ok || vin_low || vin_high;
        start_ok  = !input_bad && enabled;
        uv_any    = uv_aux || uv_main;
        uv_clear  = !uv_aux && !uv_main;
    end
endmodule

// File: rtl/pwr_uv_timer.sv
module pwr_uv_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             uv_any,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [SUM_W-1:0] nxt;

    always_comb begin
        nxt    = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
        expire = arm && uv_any && (nxt >= {1'b0, limit});
        if (!arm || !uv_any || expire) cnt_d = '0;
        else                            cnt_d = nxt[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7
    uv_gap_clears_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !uv_any |=> (cnt_q == '0));

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   input_bad,
    input  logic   enabled,
    input  logic   start_ok,
    input  logic   en_pin,
    input  logic   vin_low,
    input  logic   boot_low,
    input  logic   boot_above,
    input  logic   uv_clear,
    input  logic   expire,
    output logic   run_aux,
    output logic   run_main,
    output logic   latched_off,
    output logic   arm,
    output cause_e cause
);
    seq_regs_t r_d, r_q;
    logic      rearm_evt;

    always_comb begin
        r_d         = r_q;
        r_d.en_prev = en_pin;
        r_d.vl_prev = vin_low;
        rearm_evt   = (en_pin != r_q.en_prev) || (vin_low != r_q.vl_prev);

        unique case (r_q.state)
            ST_IDLE: begin
                if (start_ok) begin
                    r_d.state = ST_AUX;
                    r_d.cause = CAUSE_NONE;
                end
            end
            ST_AUX, ST_BOTH: begin
                if (expire) begin
                    r_d.state = ST_LATCH;
                    r_d.cause = CAUSE_UVTIME;
                end else if (input_bad) begin
                    r_d.state = ST_HOLD;
                    r_d.cause = CAUSE_INPUT;
                end else if (!enabled) begin
                    r_d.state = ST_HOLD;
                    r_d.cause = CAUSE_DISABLE;
                end else if (r_q.state == ST_AUX && boot_above) begin
                    r_d.state = ST_BOTH;
                end
            end
            ST_HOLD: begin
                if (start_ok && boot_low) begin
                    r_d.state = ST_AUX;
                    r_d.cause = CAUSE_NONE;
                end
            end
            ST_LATCH: begin
                if (uv_clear && boot_low && rearm_evt) r_d.state = ST_HOLD;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= ST_IDLE;
            r_q.cause   <= CAUSE_NONE;
            r_q.en_prev <= 1'b1;
            r_q.vl_prev <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        run_aux     = (r_q.state == ST_AUX) || (r_q.state == ST_BOTH);
        run_main    = (r_q.state == ST_BOTH);
        latched_off = (r_q.state == ST_LATCH);
        arm         = run_aux;
        cause       = r_q.cause;
    end

    // R2
    input_fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        input_bad |=> (!run_aux && !run_main));

    // R3
    aux_start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_aux) |-> $past(start_ok));

    // R4
    main_after_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_main) |-> ($past(boot_above) && $past(run_aux)));

    // R5
    restart_boot_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(run_aux) && ($past(cause) != CAUSE_NONE)) |-> $past(boot_low));

    // R8
    latch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(latched_off) |-> $past(uv_clear && boot_low));

endmodule

// File: rtl/pwr_seq_supervisor.sv
module pwr_seq_supervisor
    import pwr_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok,
    input  logic             ref_ok,
    input  logic             vin_low,
    input  logic             vin_high,
    input  logic             en_pin,
    input  logic             prog_pin,
    input  logic             uv_aux,
    input  logic             uv_main,
    input  logic             boot_low,
    input  logic             boot_above,
    input  logic [CNT_W-1:0] uv_limit,
    output logic             run_aux,
    output logic             run_main,
    output logic             latched_off,
    output logic [1:0]       fault_cause
);
    logic   enabled, input_bad, start_ok, uv_any, uv_clear;
    logic   arm, expire;
    cause_e cause;

    pwr_cond_eval u_cond (
        .supply_ok (supply_ok),
        .ref_ok    (ref_ok),
        .vin_low   (vin_low),
        .vin_high  (vin_high),
        .en_pin    (en_pin),
        .prog_pin  (prog_pin),
        .uv_aux    (uv_aux),
        .uv_main   (uv_main),
        .enabled   (enabled),
        .input_bad (input_bad),
        .start_ok  (start_ok),
        .uv_any    (uv_any),
        .uv_clear  (uv_clear)
    );

    pwr_uv_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (arm),
        .uv_any (uv_any),
        .limit  (uv_limit),
        .expire (expire)
    );

    pwr_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .input_bad   (input_bad),
        .enabled     (enabled),
        .start_ok    (start_ok),
        .en_pin      (en_pin),
        .vin_low     (vin_low),
        .boot_low    (boot_low),
        .boot_above  (boot_above),
        .uv_clear    (uv_clear),
        .expire      (expire),
        .run_aux     (run_aux),
        .run_main    (run_main),
        .latched_off (latched_off),
        .arm         (arm),
        .cause       (cause)
    );

    assign fault_cause = cause;

endmodule

// File: tb/test_pwr_seq_supervisor.sv
module test_pwr_seq_supervisor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        supply_ok, ref_ok, vin_low, vin_high, en_pin, prog_pin;
    logic        uv_aux, uv_main, boot_low, boot_above;
    logic [15:0] uv_limit;
    logic        run_aux, run_main, latched_off;
    logic [1:0]  fault_cause;
    int          total = 0;
    int          bad = 0;

    localparam logic [4:0] OFF0 = 5'b00000;
    localparam logic [4:0] AUXR = 5'b10000;
    localparam logic [4:0] BOTH = 5'b11000;
    localparam logic [4:0] LAT  = 5'b00111;

    always #10 clk = ~clk;

    pwr_seq_supervisor #(.CNT_W(16)) i_pwr_seq_supervisor (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ref_ok(ref_ok),
        .vin_low(vin_low), .vin_high(vin_high), .en_pin(en_pin), .prog_pin(prog_pin),
        .uv_aux(uv_aux), .uv_main(uv_main), .boot_low(boot_low), .boot_above(boot_above),
        .uv_limit(uv_limit), .run_aux(run_aux), .run_main(run_main),
        .latched_off(latched_off), .fault_cause(fault_cause)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [4:0] exp);
        logic [4:0] obs;
        obs = {run_aux, run_main, latched_off, fault_cause};
        total++;
        if (obs !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b", req, obs, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        supply_ok = 1'b1; ref_ok = 1'b1; vin_low = 1'b0; vin_high = 1'b0;
        en_pin = 1'b0; prog_pin = 1'b0; uv_aux = 1'b0; uv_main = 1'b0;
        boot_low = 1'b1; boot_above = 1'b0; uv_limit = 16'd4;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic bring_up();
        prog_pin = 1'b0; en_pin = 1'b1;
        tick(); chk("R3 aux start", AUXR);
        boot_above = 1'b1; boot_low = 1'b0;
        tick(); chk("R4 main after boot", BOTH);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got hung expected done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R3 reset state and start gating on reference
        do_reset();
        chk("R3 reset state", OFF0);
        en_pin = 1'b1; ref_ok = 1'b0;
        tick(); chk("R3 no start without reference", OFF0);
        ref_ok = 1'b1;
        tick(); chk("R3 aux one clock after good", AUXR);
        tick(); chk("R4 main waits for boot_above", AUXR);
        boot_above = 1'b1;
        tick(); chk("R4 main one clock after boot_above", BOTH);

        // R1 enable polarity sweep
        for (int p = 0; p < 2; p++) begin
            for (int e = 0; e < 2; e++) begin
                do_reset();
                prog_pin = p[0]; en_pin = e[0];
                tick();
                chk("R1 enable decode", (e[0] ^ p[0]) ? AUXR : OFF0);
                if (e[0] ^ p[0]) begin
                    en_pin = ~en_pin;
                    tick(); chk("R1 disable stops", 5'b00010);
                end
            end
        end

        // R2 each input fault while running
        for (int f = 0; f < 4; f++) begin
            do_reset();
            bring_up();
            case (f)
                0: ref_ok = 1'b0;
                1: supply_ok = 1'b0;
                2: vin_low = 1'b1;
                default: vin_high = 1'b1;
            endcase
            tick(); chk("R2 input fault stops both", 5'b00001);
        end

        // R5 auto restart needs boot_low, full order repeats
        do_reset();
        bring_up();
        vin_high = 1'b1;
        tick(); chk("R5 fault stop", 5'b00001);
        vin_high = 1'b0;
        tick(); chk("R5 held while rail up, main not early", 5'b00001);
        tick(); chk("R5 still held", 5'b00001);
        boot_low = 1'b1;
        tick(); chk("R5 restart aux first", AUXR);
        boot_low = 1'b0;
        tick(); chk("R5 then main", BOTH);

        // R6 trip count sweep, including limit zero
        for (int lim = 0; lim <= 6; lim++) begin
            int n;
            do_reset();
            uv_limit = 16'(lim);
            bring_up();
            if (lim % 2 == 1) uv_aux = 1'b1;
            else              uv_main = 1'b1;
            n = (lim == 0) ? 1 : lim;
            for (int i = 1; i < n; i++) begin
                tick(); chk("R6 running before limit", BOTH);
            end
            tick(); chk("R6 latched at limit", LAT);
        end

        // R6 timer idle while off, then counts from aux entry
        do_reset();
        uv_aux = 1'b1;
        repeat (10) tick();
        chk("R6 no count while off", OFF0);
        en_pin = 1'b1;
        tick(); chk("R6 aux starts with uv", AUXR);
        for (int i = 1; i < 4; i++) begin
            tick(); chk("R6 counting in aux", AUXR);
        end
        tick(); chk("R6 latched from aux", LAT);

        // R7 gaps clear the timer; flag handover keeps counting
        do_reset();
        bring_up();
        for (int k = 0; k < 3; k++) begin
            uv_aux = 1'b1;
            repeat (3) tick();
            uv_aux = 1'b0;
            tick();
        end
        chk("R7 gaps never latch", BOTH);
        uv_aux = 1'b1;
        tick(); tick();
        uv_aux = 1'b0; uv_main = 1'b1;
        tick(); chk("R6 either flag continues count", BOTH);
        tick(); chk("R6 latch after handover", LAT);

        // R8 latch release rules (prog low, en high, boot_low low now)
        en_pin = 1'b0; boot_low = 1'b1;
        tick(); chk("R8 toggle ignored while uv high", LAT);
        uv_main = 1'b0; en_pin = 1'b1; boot_low = 1'b0;
        tick(); chk("R8 toggle ignored while rail up", LAT);
        boot_low = 1'b1;
        tick(); chk("R8 no release without toggle", LAT);
        en_pin = 1'b0;
        tick(); chk("R8 release keeps cause", 5'b00011);
        en_pin = 1'b1;
        tick(); chk("R8 restart aux first", AUXR);
        tick(); chk("R8 restart main second", BOTH);

        // R8 release by input undervoltage toggle
        uv_aux = 1'b1;
        repeat (4) tick();
        chk("R8 latched again", LAT);
        uv_aux = 1'b0; vin_low = 1'b1;
        tick(); chk("R8 release by vin_low toggle", 5'b00011);
        vin_low = 1'b0;
        tick(); chk("R8 restart after vin toggle", AUXR);

        // R9 priorities
        do_reset();
        uv_limit = 16'd3;
        bring_up();
        uv_main = 1'b1;
        tick(); tick();
        vin_high = 1'b1;
        tick(); chk("R9 timeout over input fault", LAT);
        do_reset();
        bring_up();
        vin_low = 1'b1; en_pin = 1'b0;
        tick(); chk("R9 input fault over disable", 5'b00001);
        do_reset();
        bring_up();
        supply_ok = 1'b0;
        tick(); chk("R9 supply loss is input cause", 5'b00001);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule